// File: doc/BRIEF.md
# Burst Read Initial Latency Controller

This block sits beside a flash-style memory array and decides when the first word of a synchronous linear burst read is ready to hand to the host. The host pulls the active-low address strobe for one clock while presenting a start address, a burst-length code and a clock-range select. From these the block works out how many wait cycles the first access needs. The count depends on the parity of the start address, on whether the burst would run past the end of the current 64-word block, and on the clock range. It then counts those cycles down and raises a ready flag for each word of the burst.

While ready is high, the block also drives the word address of the current beat. That address advances by one per cycle and is confined to the 64-word block holding the start address. When it passes the last word of the block, it wraps to the first word of the same block. A fresh strobe at any time throws away the burst in progress and starts a new latency count. The array and the data path are outside this block.

Top module: `burst_lat_ctrl`

## Requirements
- R1: After synchronous reset, `rdy` is 0 and `word_addr` is 0.
- R2: The strobe edge is the rising clock edge at which `avd_n` is sampled 0. The latency L is the number of further rising edges after which `rdy` reads 1. With `freq_hi`=0 and no block crossing, L is 4 for an even start address and 5 for an odd one.
- R3: With `freq_hi`=1 and no block crossing, L is 5 for an even start address and 6 for an odd one.
- R4: A block crossing exists when (start address mod 64) plus the burst length is greater than 64; a sum of exactly 64 is not a crossing. A crossing adds 2 to the latency: 6/7 (even/odd) with `freq_hi`=0 and 7/8 with `freq_hi`=1.
- R5: The `len_sel` code gives the burst length N: 2'b00 selects 8 words, 2'b01 selects 16 words, and 2'b10 or 2'b11 selects 32 words. `rdy` stays 1 for exactly N consecutive cycles and then returns to 0.
- R6: During beat k (k = 0..N-1) of the burst, `word_addr` equals the start address with its low 6 bits replaced by (start mod 64 + k) mod 64. The upper bits never change, so the pointer wraps within the block.
- R7: A strobe during the wait count or during a burst abandons it. `rdy` reads 0 after that strobe edge, `word_addr` shows the new start address, and the latency is counted from the new strobe.
- R8: `start_addr`, `len_sel` and `freq_hi` are sampled only at the strobe edge. Changing them while `avd_n` is 1 changes neither the latency, the burst length nor the address sequence of the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avd_n | input | 1 | Active-low address strobe; each low-sampled edge starts a burst |
| start_addr | input | ADDR_W (16) | Word address of the first beat |
| len_sel | input | 2 | Burst length code: 00=8, 01=16, 1x=32 words |
| freq_hi | input | 1 | Clock range select: 0 = low range, 1 = high range |
| rdy | output | 1 | High while the current beat's word is valid |
| word_addr | output | ADDR_W (16) | Word address of the current beat |

## Verification
The hardest case to reach is the pair of edges around the 64-word limit. A burst that ends exactly on the last word of the block must keep the short latency. One that overruns it by a single word must take the extra two cycles and then wrap its pointer to the block start. The stimulus places start offsets at 56 and 60 with an 8-word burst, at 32 with a 32-word burst, and at 49 with a 16-word burst in the high range. It follows every address beat across the wrap. The bench also fires a second strobe both in the middle of a wait count and in the middle of a data run. While a burst is running, it scrambles the sampled inputs to show that they are ignored.

// File: rtl/burst_lat_pkg.sv
package burst_lat_pkg;
    localparam int ADDR_W   = 16;
    localparam int BLK_W    = 6;
    localparam int CNT_W    = 6;
    localparam int LAT_LO   = 4;
    localparam int LAT_HI   = 5;
    localparam int XING_ADD = 2;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_DATA
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] lat;
        logic [CNT_W-1:0] words;
        logic             xing;
    } burst_req_t;

    function automatic logic [CNT_W-1:0] words_of(input logic [1:0] sel);
        logic [CNT_W-1:0] w;
        if (sel[1])      w = CNT_W'(32);
        else if (sel[0]) w = CNT_W'(16);
        else             w = CNT_W'(8);
        return w;
    endfunction
endpackage

// File: rtl/burst_lat_calc.sv
module burst_lat_calc
    import burst_lat_pkg::*;
#(
    parameter int BW      = BLK_W,
    parameter int CW      = CNT_W,
    parameter int L_LO    = LAT_LO,
    parameter int L_HI    = LAT_HI,
    parameter int X_ADD   = XING_ADD
) (
    input  logic [BW-1:0] start_lo,
    input  logic [1:0]    len_sel,
    input  logic          freq_hi,
    output burst_req_t    req
);
    localparam int SW = (BW > CW ? BW : CW) + 1;

    logic [SW-1:0] span_end;
    logic [CW-1:0] nwords;
    logic [CW-1:0] base;

    always_comb begin
        nwords   = words_of(len_sel);
        span_end = SW'(start_lo) + SW'(nwords);
        base     = freq_hi ? CW'(L_HI) : CW'(L_LO);
        req.words = nwords;
        req.xing  = span_end > SW'(1 << BW);
        req.lat   = base + CW'(start_lo[0]) + (req.xing ? CW'(X_ADD) : '0);
    end
endmodule

// File: rtl/burst_lat_seq.sv
module burst_lat_seq
    import burst_lat_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       avd_n,
    input  burst_req_t req,
    output phase_e     phase,
    output logic       step
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] words_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt_q   <= '0;
            words_q <= '0;
        end else if (!avd_n) begin
            phase   <= PH_WAIT;
            cnt_q   <= req.lat - CW'(1);
            words_q <= req.words;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (cnt_q == '0) begin
                        phase <= PH_DATA;
                        cnt_q <= words_q - CW'(1);
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_DATA: begin
                    if (cnt_q == '0) phase <= PH_IDLE;
                    else             cnt_q <= cnt_q - CW'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign step = avd_n && (phase == PH_DATA) && (cnt_q != '0);
endmodule

// File: rtl/burst_lat_ptr.sv
module burst_lat_ptr
    import burst_lat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BLK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] word_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_addr <= '0;
        end else if (load) begin
            word_addr <= start_addr;
        end else if (step) begin
            word_addr <= {word_addr[AW-1:BW], word_addr[BW-1:0] + BW'(1)};
        end
    end
endmodule

// File: rtl/burst_lat_ctrl.sv
module burst_lat_ctrl
    import burst_lat_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BLK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          avd_n,
    input  logic [AW-1:0] start_addr,
    input  logic [1:0]    len_sel,
    input  logic          freq_hi,
    output logic          rdy,
    output logic [AW-1:0] word_addr
);
    burst_req_t req;
    phase_e     phase;
    logic       step;

    burst_lat_calc #(.BW(BW)) u_calc (
        .start_lo (start_addr[BW-1:0]),
        .len_sel  (len_sel),
        .freq_hi  (freq_hi),
        .req      (req)
    );

    burst_lat_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .avd_n (avd_n),
        .req   (req),
        .phase (phase),
        .step  (step)
    );

    burst_lat_ptr #(.AW(AW), .BW(BW)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .load       (!avd_n),
        .step       (step),
        .start_addr (start_addr),
        .word_addr  (word_addr)
    );

    assign rdy = (phase == PH_DATA);
endmodule

// File: rtl/burst_lat_chk.sv
module burst_lat_chk #(
    parameter int AW      = 16,
    parameter int BW      = 6,
    parameter int MAX_RUN = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          avd_n,
    input logic [AW-1:0] start_addr,
    input logic          rdy,
    input logic [AW-1:0] word_addr
);
    logic [3:0] since_q;
    logic [6:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            run_q   <= '0;
        end else begin
            if (!avd_n)              since_q <= '0;
            else if (since_q != 4'hF) since_q <= since_q + 4'd1;
            if (rdy && run_q != 7'h7F) run_q <= run_q + 7'd1;
            else if (!rdy)             run_q <= '0;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!rdy && word_addr == '0));

    a_r4_lat_window: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (since_q >= 4'd4 && since_q <= 4'd8));

    a_r5_run_bound: assert property (@(posedge clk) disable iff (rst)
        rdy |-> (run_q < 7'(MAX_RUN)));

    a_r6_step_in_block: assert property (@(posedge clk) disable iff (rst)
        (rdy && $past(rdy)) |->
        (word_addr[AW-1:BW] == $past(word_addr[AW-1:BW]) &&
         word_addr[BW-1:0] == BW'($past(word_addr[BW-1:0]) + BW'(1))));

    a_r7_strobe_drops: assert property (@(posedge clk) disable iff (rst)
        !avd_n |=> !rdy);

    a_r7_strobe_loads: assert property (@(posedge clk) disable iff (rst)
        !avd_n |=> word_addr == $past(start_addr));
endmodule

bind burst_lat_ctrl burst_lat_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .avd_n      (avd_n),
    .start_addr (start_addr),
    .rdy        (rdy),
    .word_addr  (word_addr)
);

// File: tb/burst_lat_ctrl_test.sv
module burst_lat_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        avd_n = 1'b1;
    logic [15:0] start_addr = '0;
    logic [1:0]  len_sel = '0;
    logic        freq_hi = 1'b0;
    logic        rdy;
    logic [15:0] word_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    burst_lat_ctrl uut (
        .clk(clk), .rst(rst), .avd_n(avd_n), .start_addr(start_addr),
        .len_sel(len_sel), .freq_hi(freq_hi), .rdy(rdy), .word_addr(word_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at posedge+2; strobe edge is the next posedge, then inputs are scrambled.
    task automatic strobe(input logic [15:0] a, input logic [1:0] l, input logic f);
        avd_n = 1'b0; start_addr = a; len_sel = l; freq_hi = f;
        @(posedge clk); #2;
        avd_n = 1'b1; start_addr = ~a; len_sel = ~l; freq_hi = ~f;
    endtask

    task automatic measure(input string tag, input logic [15:0] a, input int lat, input int n);
        int got = 0;
        for (int c = 1; c <= 12; c++) begin
            @(posedge clk); #2;
            if (rdy === 1'b1) begin got = c; break; end
        end
        check({tag, " latency"}, got, lat);
        if (got != 0) begin
            check({tag, " R6 first word"}, word_addr, a);
            for (int k = 1; k <= n; k++) begin
                @(posedge clk); #2;
                if (k < n) begin
                    check({tag, " R5 rdy held"}, rdy, 1'b1);
                    check({tag, " R6 word"}, word_addr, {a[15:6], 6'(a[5:0] + 6'(k))});
                end else begin
                    check({tag, " R5 rdy ends"}, rdy, 1'b0);
                end
            end
        end
    endtask

    task automatic t_reset();
        check("R1 rdy", rdy, 1'b0);
        check("R1 word_addr", word_addr, 16'h0);
    endtask

    task automatic t_low_range();
        strobe(16'h0100, 2'b00, 1'b0); measure("R2 low even", 16'h0100, 4, 8);
        strobe(16'h0103, 2'b01, 1'b0); measure("R2 low odd", 16'h0103, 5, 16);
    endtask

    task automatic t_high_range();
        strobe(16'h0200, 2'b00, 1'b1); measure("R3 high even", 16'h0200, 5, 8);
        strobe(16'h0201, 2'b00, 1'b1); measure("R3 high odd", 16'h0201, 6, 8);
    endtask

    task automatic t_crossing();
        strobe(16'h413C, 2'b00, 1'b0); measure("R4 low even cross", 16'h413C, 6, 8);
        strobe(16'h413D, 2'b00, 1'b0); measure("R4 low odd cross", 16'h413D, 7, 8);
        strobe(16'h0AA8, 2'b10, 1'b1); measure("R4 high even cross", 16'h0AA8, 7, 32);
        strobe(16'h0AB1, 2'b01, 1'b1); measure("R4 high odd cross", 16'h0AB1, 8, 16);
        strobe(16'h0138, 2'b00, 1'b0); measure("R4 exact 64 len8", 16'h0138, 4, 8);
        strobe(16'h0160, 2'b10, 1'b0); measure("R4 exact 64 len32", 16'h0160, 4, 32);
    endtask

    task automatic t_len_code3();
        strobe(16'h0300, 2'b11, 1'b0); measure("R5 code 11", 16'h0300, 4, 32);
    endtask

    task automatic t_restart_wait();
        strobe(16'h0500, 2'b00, 1'b0);
        @(posedge clk); #2;
        strobe(16'h0611, 2'b00, 1'b1);
        check("R7 rdy after restart", rdy, 1'b0);
        check("R7 addr after restart", word_addr, 16'h0611);
        measure("R7 wait restart", 16'h0611, 6, 8);
    endtask

    task automatic t_restart_data();
        strobe(16'h0700, 2'b01, 1'b0);
        repeat (6) begin @(posedge clk); #2; end
        check("R7 mid burst rdy", rdy, 1'b1);
        strobe(16'h0820, 2'b00, 1'b0);
        check("R7 data restart rdy", rdy, 1'b0);
        measure("R7 data restart", 16'h0820, 4, 8);
    endtask

    task automatic t_ignore();
        // strobe() drives inverted address, length and range while avd_n is high.
        strobe(16'h0902, 2'b00, 1'b0); measure("R8 ignored inputs", 16'h0902, 4, 8);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        t_reset();
        @(posedge clk); #2;
        t_low_range();
        t_high_range();
        t_crossing();
        t_len_code3();
        t_restart_wait();
        t_restart_data();
        t_ignore();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule